// File: doc/BRIEF.md
# MDIO Management Master with Extended Register Access

This block is a management-bus master. A host issues one command at a time. The command gives the access kind, the addresses, write data and the MDC half-period, and a one-cycle start pulse launches it. The master derives MDC from the system clock. It then serializes a 64-bit management frame on MDIO, made of a preamble, start bits, opcode, two address fields, turnaround and 16 data bits. On reads it releases the line during turnaround and data, and shifts in what the PHY returns.

Besides the two standard accesses, the master issues an extended access that reaches an 8-bit register space through the reserved opcode 00. For these accesses it splits the 8-bit address across the PHY and register fields and carries the direction in PHY address bit 4. Extended data is one byte, carried in the low half of the 16-bit data field. When a frame ends, the master releases the line and inserts one idle MDC period. It then pulses `done` and presents the read data.

Top module: `mdio_master`

## Requirements
- R1: After reset `mdc` is 0, `mdio_oe` is 0, `busy` is 0 and `done` is 0. Whenever `busy` is 0, `mdc` and `mdio_oe` stay 0.
- R2: Every frame, sent MSB first, begins with 32 ones followed by the bits 0 then 1.
- R3: A standard read is selected by `access`=0. Its frame carries opcode 10, then `phy_addr`, then `reg_addr`, each MSB first. `mdio_oe` is 0 during the two turnaround bits and the 16 data bits. `rdata` returns the 16 bits sampled on `mdio_i` at the MDC rising edges of the data bits, the first sampled bit in bit 15.
- R4: A standard write is selected by `access`=1. Its frame carries opcode 01, `phy_addr`, `reg_addr`, turnaround 1 then 0, and then `wdata` MSB first. `mdio_oe` is 1 for all 64 bits.
- R5: Extended accesses are selected by `access`=2 (read) and `access`=3 (write). They send opcode 00 and the PHY field {dir, 0, ext_addr[7:5]}, where dir is 1 for a read and 0 for a write. The register field carries `ext_addr[4:0]`.
- R6: An extended write sends the 16-bit data field {8'h00, wdata[7:0]}, with turnaround 1 then 0.
- R7: An extended read returns `rdata` = {8'h00, low byte of the 16 sampled bits}.
- R8: Each MDC phase, high or low, lasts max(`half_period`, MIN_HALF) system clocks. MIN_HALF is derived from the parameters so that MDC never exceeds 5 MHz, and it is 20 at the default 200 MHz clock.
- R9: `mdio_o` and `mdio_oe` change only while MDC is low. They are stable throughout every MDC high phase.
- R10: After the last data bit, `mdio_oe` drops to 0 and one full idle MDC period follows with the line released. Then `done` pulses for exactly one cycle and `busy` falls in the same cycle. A start pulse while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a command when idle |
| access | input | 2 | 0 std read, 1 std write, 2 ext read, 3 ext write |
| phy_addr | input | 5 | PHY address for standard accesses |
| reg_addr | input | 5 | Register address for standard accesses |
| ext_addr | input | 8 | Register address for extended accesses |
| wdata | input | 16 | Write data (low byte used for extended writes) |
| half_period | input | DIV_W | Requested MDC half-period in system clocks |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Serial data in |

## Verification
Directed frames cover each of the four access kinds at extreme field values, such as all-ones addresses, a 0xE0/0x1F extended address and wdata 0xA55A. These frames show whether the opcode, the direction bit and the address split land in the right positions. A half-period below the floor and one above it show whether the clamp or the requested value sets the MDC phase. A start pulse injected mid-frame, with different fields, tells a master that ignores it from one that corrupts the frame. Random commands with random response words separate bit-order and byte-masking faults, and so do read responses whose high byte is nonzero on extended reads.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
   typedef enum logic [1:0] {
      ACC_STD_RD = 2'd0,
      ACC_STD_WR = 2'd1,
      ACC_EXT_RD = 2'd2,
      ACC_EXT_WR = 2'd3
   } mdio_access_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_TAIL  = 2'd2
   } mdio_state_e;

   localparam int FRAME_BITS = 64;
   localparam int DATA_BITS  = 16;
   localparam int TA_FIRST   = FRAME_BITS - DATA_BITS - 2;  // index of first turnaround bit
   localparam int DATA_FIRST = FRAME_BITS - DATA_BITS;      // index of first data bit
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W    = 8,
   parameter int MIN_HALF = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half_req,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   localparam int RUN_W = DIV_W + 1;

   logic [DIV_W-1:0] half_eff;
   logic [DIV_W-1:0] cnt;
   logic             tick;

   initial assert (MIN_HALF >= 1 && MIN_HALF < (1 << DIV_W))
      else $error("mdio_clkgen: MIN_HALF must fit in DIV_W bits");

   generate
      if (MIN_HALF > 1) begin : g_clamp
         assign half_eff = (half_req < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_req;
      end else begin : g_nonzero
         assign half_eff = (half_req == '0) ? DIV_W'(1) : half_req;
      end
   endgenerate

   assign tick      = en && (cnt == half_eff - DIV_W'(1));
   assign rise_tick = tick && !mdc;
   assign fall_tick = tick && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end

   // Phase-length observer: cycles mdc held its value before the latest change
   logic             mdc_q;
   logic [RUN_W-1:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
         run   <= '1;
      end else begin
         mdc_q <= mdc;
         if (mdc != mdc_q)   run <= RUN_W'(1);
         else if (run != '1) run <= run + RUN_W'(1);
      end
   end

   // R8: no MDC phase shorter than the floor
   p_phase_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc != mdc_q) |-> (run >= RUN_W'(MIN_HALF)));
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
   import mdio_master_pkg::*;
#(
   parameter bit EXT_PHY_B3 = 1'b0
) (
   input  logic [1:0]            access,
   input  logic [4:0]            phy_addr,
   input  logic [4:0]            reg_addr,
   input  logic [7:0]            ext_addr,
   input  logic [DATA_BITS-1:0]  wdata,
   output logic [FRAME_BITS-1:0] frame,
   output logic [FRAME_BITS-1:0] oe_mask,
   output logic                  is_read,
   output logic                  is_ext
);
   mdio_access_e acc;
   logic [1:0]   op;
   logic [4:0]   phy_f, reg_f;
   logic [15:0]  data_f;
   logic [1:0]   ta_f;

   assign acc     = mdio_access_e'(access);
   assign is_read = (acc == ACC_STD_RD) || (acc == ACC_EXT_RD);
   assign is_ext  = (acc == ACC_EXT_RD) || (acc == ACC_EXT_WR);

   always_comb begin
      op     = 2'b00;
      phy_f  = {~acc[0], EXT_PHY_B3, ext_addr[7:5]};
      reg_f  = ext_addr[4:0];
      data_f = {8'h00, wdata[7:0]};
      unique case (acc)
         ACC_STD_RD: begin op = 2'b10; phy_f = phy_addr; reg_f = reg_addr; data_f = '0;    end
         ACC_STD_WR: begin op = 2'b01; phy_f = phy_addr; reg_f = reg_addr; data_f = wdata; end
         ACC_EXT_RD: data_f = '0;
         ACC_EXT_WR: ;
         default:    ;
      endcase
      ta_f    = is_read ? 2'b00 : 2'b10;
      frame   = {32'hFFFF_FFFF, 2'b01, op, phy_f, reg_f, ta_f, data_f};
      oe_mask = is_read ? {{(FRAME_BITS-DATA_BITS-2){1'b1}}, {(DATA_BITS+2){1'b0}}}
                        : {FRAME_BITS{1'b1}};
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_master_pkg::*;
#(
   parameter int SYS_CLK_KHZ = 200000,
   parameter int MDC_MAX_KHZ = 5000,
   parameter int DIV_W       = 8,
   parameter bit EXT_PHY_B3  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       access,
   input  logic [4:0]       phy_addr,
   input  logic [4:0]       reg_addr,
   input  logic [7:0]       ext_addr,
   input  logic [15:0]      wdata,
   input  logic [DIV_W-1:0] half_period,
   output logic             busy,
   output logic             done,
   output logic [15:0]      rdata,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   localparam int MIN_HALF = (SYS_CLK_KHZ + 2*MDC_MAX_KHZ - 1) / (2*MDC_MAX_KHZ);
   localparam int CNT_W    = $clog2(FRAME_BITS);

   initial assert (MDC_MAX_KHZ > 0 && SYS_CLK_KHZ >= 2*MDC_MAX_KHZ)
      else $error("mdio_master: system clock too slow for MDC limit");
   initial assert (MIN_HALF < (1 << DIV_W))
      else $error("mdio_master: DIV_W too narrow for MIN_HALF");

   mdio_state_e           state;
   logic [CNT_W-1:0]      bit_cnt;
   logic [FRAME_BITS-1:0] sh_data, sh_oe;
   logic [FRAME_BITS-1:0] frame_n, oe_n;
   logic                  rd_n, ext_n, rd_q, ext_q;
   logic [DATA_BITS-1:0]  cap;
   logic [DIV_W-1:0]      half_q;
   logic                  rise_tick, fall_tick;

   mdio_framer #(.EXT_PHY_B3(EXT_PHY_B3)) u_framer (
      .access  (access),
      .phy_addr(phy_addr),
      .reg_addr(reg_addr),
      .ext_addr(ext_addr),
      .wdata   (wdata),
      .frame   (frame_n),
      .oe_mask (oe_n),
      .is_read (rd_n),
      .is_ext  (ext_n)
   );

   mdio_clkgen #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (state != ST_IDLE),
      .half_req (half_q),
      .mdc      (mdc),
      .rise_tick(rise_tick),
      .fall_tick(fall_tick)
   );

   assign busy    = (state != ST_IDLE);
   assign mdio_oe = (state == ST_FRAME) && sh_oe[FRAME_BITS-1];
   assign mdio_o  = mdio_oe && sh_data[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         sh_data <= '0;
         sh_oe   <= '0;
         rd_q    <= 1'b0;
         ext_q   <= 1'b0;
         cap     <= '0;
         half_q  <= '0;
         rdata   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state   <= ST_FRAME;
               bit_cnt <= '0;
               sh_data <= frame_n;
               sh_oe   <= oe_n;
               rd_q    <= rd_n;
               ext_q   <= ext_n;
               half_q  <= half_period;
            end
            ST_FRAME: begin
               if (rise_tick && rd_q && (bit_cnt >= CNT_W'(DATA_FIRST)))
                  cap <= {cap[DATA_BITS-2:0], mdio_i};
               if (fall_tick) begin
                  if (bit_cnt == CNT_W'(FRAME_BITS-1)) begin
                     state <= ST_TAIL;
                  end else begin
                     bit_cnt <= bit_cnt + CNT_W'(1);
                     sh_data <= {sh_data[FRAME_BITS-2:0], 1'b0};
                     sh_oe   <= {sh_oe[FRAME_BITS-2:0], 1'b0};
                  end
               end
            end
            ST_TAIL: if (fall_tick) begin
               state <= ST_IDLE;
               done  <= 1'b1;
               rdata <= ext_q ? {8'h00, cap[7:0]} : cap;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: bus quiet whenever no frame is in progress
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));
   // R9: data and enable frozen while MDC is high
   p_stable_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
   // R3: line released for turnaround and data on reads
   p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FRAME && rd_q && bit_cnt >= CNT_W'(TA_FIRST)) |-> !mdio_oe);
   // R10: done is a single-cycle pulse, and the master is idle when it fires
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));
   // R10: tail period keeps the line released
   p_tail_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TAIL) |-> !mdio_oe);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
   localparam int DIV_W    = 8;
   localparam int MIN_HALF = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       access = '0;
   logic [4:0]       phy_addr = '0, reg_addr = '0;
   logic [7:0]       ext_addr = '0;
   logic [15:0]      wdata = '0;
   logic [DIV_W-1:0] half_period = 8'd20;
   logic             busy, done, mdc, mdio_o, mdio_oe;
   logic             mdio_i = 1'b0;
   logic [15:0]      rdata;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   mdio_master u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .access(access),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .ext_addr(ext_addr),
      .wdata(wdata), .half_period(half_period), .busy(busy), .done(done),
      .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         errors++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input logic [1:0] acc, input logic [4:0] pa,
         input logic [4:0] ra, input logic [7:0] ea, input logic [15:0] wd);
      logic [1:0] op; logic [4:0] p, r; logic [1:0] ta; logic [15:0] d;
      case (acc)
         2'd0: begin op = 2'b10; p = pa; r = ra; ta = 2'b00; d = 16'h0; end
         2'd1: begin op = 2'b01; p = pa; r = ra; ta = 2'b10; d = wd; end
         2'd2: begin op = 2'b00; p = {2'b10, ea[7:5]}; r = ea[4:0]; ta = 2'b00; d = 16'h0; end
         default: begin op = 2'b00; p = {2'b00, ea[7:5]}; r = ea[4:0]; ta = 2'b10; d = {8'h00, wd[7:0]}; end
      endcase
      return {32'hFFFF_FFFF, 2'b01, op, p, r, ta, d};
   endfunction

   function automatic logic [63:0] exp_oe(input logic [1:0] acc);
      return (acc == 2'd0 || acc == 2'd2) ? {46'h3FFF_FFFF_FFFF, 18'h0} : {64{1'b1}};
   endfunction

   function automatic string tag(input logic [1:0] acc);
      case (acc)
         2'd0: return "R3 std read";
         2'd1: return "R4 std write";
         2'd2: return "R5 ext read";
         default: return "R5/R6 ext write";
      endcase
   endfunction

   task automatic run(input logic [1:0] acc, input logic [4:0] pa, input logic [4:0] ra,
         input logic [7:0] ea, input logic [15:0] wd, input logic [7:0] hp,
         input logic [15:0] resp, input bit inject);
      logic [63:0] got = '0, goe = '0, ef, eo;
      int hmeas = 0, unstable = 0, tail_hi = 0, tail_oe = 0, tcnt = 0;
      int exp_half;
      logic [15:0] erd;
      ef = exp_frame(acc, pa, ra, ea, wd);
      eo = exp_oe(acc);
      exp_half = (hp < MIN_HALF) ? MIN_HALF : hp;
      @(negedge clk);
      access = acc; phy_addr = pa; reg_addr = ra; ext_addr = ea; wdata = wd;
      half_period = hp; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int b = 0; b < 64; b++) begin
         mdio_i = (b >= 48) ? resp[63-b] : 1'b0;
         if (inject && b == 20) begin
            access = ~acc; phy_addr = ~pa; reg_addr = ~ra; ext_addr = ~ea; wdata = ~wd;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
         while (!mdc) @(negedge clk);
         got[63-b] = mdio_o;
         goe[63-b] = mdio_oe;
         begin
            int hc = 0;
            while (mdc) begin
               if (mdio_o !== got[63-b] || mdio_oe !== goe[63-b]) unstable++;
               hc++;
               @(negedge clk);
            end
            if (b == 10) hmeas = hc;
         end
      end
      while (!done && tcnt < 2000) begin
         if (mdc) tail_hi++;
         if (mdio_oe) tail_oe++;
         tcnt++;
         @(negedge clk);
      end
      check("R2 preamble+start", {30'h0, got[63:30]}, {30'h0, 32'hFFFF_FFFF, 2'b01});
      check(tag(acc), got & eo, ef & eo);
      check({tag(acc), " oe"}, goe, eo);
      check("R8 half period", 64'(hmeas), 64'(exp_half));
      check("R9 stable while high", 64'(unstable), 64'd0);
      check("R10 idle tail high", 64'(tail_hi), 64'(exp_half));
      check("R10 tail released", 64'(tail_oe), 64'd0);
      check("R10 done with busy low", {62'h0, done, busy}, {62'h0, 1'b1, 1'b0});
      if (acc == 2'd0 || acc == 2'd2) begin
         erd = (acc == 2'd2) ? {8'h00, resp[7:0]} : resp;
         check((acc == 2'd2) ? "R7 ext read data" : "R3 read data", 64'(rdata), 64'(erd));
      end
      @(negedge clk);
      check("R10 single done, no restart", {62'h0, done, busy}, 64'h0);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("R1 reset state", {60'h0, mdc, mdio_oe, busy, done}, 64'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle after reset", {60'h0, mdc, mdio_oe, busy, done}, 64'h0);
      // directed corners
      run(2'd0, 5'h1F, 5'h00, 8'h00, 16'h0000, 8'd3,  16'hC3A5, 1'b0);
      run(2'd1, 5'h00, 5'h1F, 8'h00, 16'hA55A, 8'd25, 16'h0000, 1'b0);
      run(2'd2, 5'h00, 5'h00, 8'hE0, 16'h0000, 8'd20, 16'hFF3C, 1'b0);
      run(2'd3, 5'h00, 5'h00, 8'h1F, 16'hBE81, 8'd21, 16'h0000, 1'b0);
      run(2'd1, 5'h15, 5'h0A, 8'h00, 16'h1234, 8'd20, 16'h0000, 1'b1);
      run(2'd2, 5'h00, 5'h00, 8'hA7, 16'h0000, 8'd0,  16'h81C7, 1'b1);
      // random commands
      for (int i = 0; i < 20; i++) begin
         logic [1:0] a = 2'($urandom);
         logic [4:0] p = 5'($urandom), r = 5'($urandom);
         logic [7:0] e = 8'($urandom);
         logic [15:0] w = 16'($urandom), rs = 16'($urandom);
         logic [7:0] h = 8'(18 + ($urandom % 6));
         run(a, p, r, e, w, h, rs, 1'b0);
      end
      summary();
      $finish;
   end
endmodule